// File: doc/BRIEF.md
# Receive Character Queue with Line-Error Tracking

This block is the receive-side character store of a serial port. The receiver writes each assembled character into it together with three flags: parity error, framing error and break. The host reads characters from the head of the store. The block drives the error portion of the line status word. A 3-bit field shows the flags of the head character. A summary bit stays high while any stored character, at any depth, still carries a flag. The block also keeps a sticky overrun flag and a data-ready bit, and raises a line-status interrupt request.

Occupancy is tracked by a three-state machine:

- States: `OCC_EMPTY`, `OCC_PART`, `OCC_FULL`.
- Transitions:
  - `OCC_EMPTY`→`OCC_PART` on an accepted write.
  - `OCC_PART`→`OCC_FULL` on a write without a read when one slot is left.
  - `OCC_PART`→`OCC_EMPTY` on a read without a write when one character is left.
  - `OCC_FULL`→`OCC_PART` on a read.
  - Every other case holds the state, including a write and a read together in `OCC_PART`.

A separate counter holds the number of stored characters that carry any flag. It rises on an accepted flagged write and falls when a flagged head is read. The summary bit is simply this count being non-zero.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the store is empty. `data_ready`, `err_any`, `overrun`, `lsi_req` and `head_err` are all 0.
- R2: Characters leave in the order they were written. `rd_data` shows the head character. `data_ready` is 1 exactly when at least one character is stored.
- R3: The store holds DEPTH characters (default 64). A write while it holds DEPTH characters is discarded and leaves the contents unchanged, even if a read happens in the same cycle.
- R4: `head_err` shows the flags of the head character, with bit 2 = break, bit 1 = framing, bit 0 = parity. After each read it shows the flags of the new head.
- R5: While the store is empty, `head_err` and `rd_data` are zero.
- R6: `err_any` is 1 while at least one stored character has any flag set. It returns to 0 only once no flagged character remains anywhere in the store.
- R7: In a cycle with both an accepted write and an accepted read, the flagged-character count adds the written entry's flag and removes the read entry's flag.
- R8: An `ovr_pulse` while the store is full sets `overrun`. The character offered in that cycle is discarded.
- R9: `overrun` is cleared only by `rd_lsr`; reads of characters do not clear it. If set and clear occur in the same cycle, the set wins.
- R10: An `ovr_pulse` while the store is not full has no effect on `overrun`.
- R11: `lsi_req` is 1 exactly when `err_any` or `overrun` is 1.
- R12: A read request while the store is empty is ignored and the store stays empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Receiver offers a character this cycle |
| wr_data | input | DATA_W | Received character |
| wr_flags | input | 3 | Flags of the offered character: bit 2 break, bit 1 framing, bit 0 parity |
| ovr_pulse | input | 1 | Receiver reports a character arriving with no room |
| rd_pop | input | 1 | Host reads the head character |
| rd_lsr | input | 1 | Host reads the line status word |
| rd_data | output | DATA_W | Head character, zero when empty |
| head_err | output | 3 | Head character flags, zero when empty |
| err_any | output | 1 | Some stored character carries a flag |
| overrun | output | 1 | Sticky overrun flag |
| data_ready | output | 1 | Store is not empty |
| lsi_req | output | 1 | Line-status interrupt request |

## Verification
The bench builds the block with DEPTH = 4 and DATA_W = 8. This makes the full state, the discard of writes and overrun reachable within a handful of cycles. The bench sweeps all eight flag combinations on a single entry and then on every slot of a full store. It drives every combination of write, read, overrun and status-read strobes in each occupancy state. A long pseudo-random sequence is compared cycle by cycle against an arithmetic queue model. The small depth lets the flagged-entry count pass through every value from 0 to full many times, including simultaneous write and read of flagged entries.

// File: rtl/rxef_pkg.sv
package rxef_pkg;
    localparam int ERR_W   = 3;
    localparam int ERR_BRK = 2;
    localparam int ERR_FRM = 1;
    localparam int ERR_PAR = 0;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } rxef_occ_e;
endpackage

// File: rtl/rxef_occ.sv
module rxef_occ
    import rxef_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          push_ok,
    output logic          pop_ok,
    output rxef_occ_e     state,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr,
    output logic [CW-1:0] count
);
    rxef_occ_e state_nx;

    always_comb begin
        push_ok = push_req && (state != OCC_FULL);
        pop_ok  = pop_req  && (state != OCC_EMPTY);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            OCC_EMPTY: if (push_ok) state_nx = OCC_PART;
            OCC_PART: begin
                if (push_ok && !pop_ok && count == CW'(DEPTH - 1))
                    state_nx = OCC_FULL;
                else if (pop_ok && !push_ok && count == CW'(1))
                    state_nx = OCC_EMPTY;
            end
            OCC_FULL:  if (pop_ok) state_nx = OCC_PART;
            default:   state_nx = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OCC_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop_ok)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

    initial begin
        if (DEPTH < 2) $error("rxef_occ: DEPTH must be at least 2");
    end

    // R3: occupancy never exceeds capacity
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R12: a lone read request on an empty store leaves it empty
    a_r12_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OCC_EMPTY && pop_req && !push_req) |=> (state == OCC_EMPTY));
endmodule

// File: rtl/rxef_store.sv
module rxef_store #(
    parameter int DEPTH = 64,
    parameter int W     = 11,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [PW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rxef_errcnt.sv
module rxef_errcnt #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          any
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else begin
            unique case ({inc, dec})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign any = (cnt != '0);

    // R7: a flagged write paired with a flagged read leaves the count alone
    a_r7_balance: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
    import rxef_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ERR_W-1:0]  wr_flags,
    input  logic              ovr_pulse,
    input  logic              rd_pop,
    input  logic              rd_lsr,
    output logic [DATA_W-1:0] rd_data,
    output logic [ERR_W-1:0]  head_err,
    output logic              err_any,
    output logic              overrun,
    output logic              data_ready,
    output logic              lsi_req
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int EW = DATA_W + ERR_W;

    logic            push_ok, pop_ok;
    rxef_occ_e       occ;
    logic [PW-1:0]   wptr, rptr;
    logic [CW-1:0]   count, err_cnt;
    logic [EW-1:0]   head_word;
    logic            head_flagged;

    rxef_occ #(.DEPTH(DEPTH)) u_occ (
        .clk(clk), .rst_n(rst_n),
        .push_req(wr_valid), .pop_req(rd_pop),
        .push_ok(push_ok), .pop_ok(pop_ok),
        .state(occ), .wptr(wptr), .rptr(rptr), .count(count)
    );

    rxef_store #(.DEPTH(DEPTH), .W(EW)) u_store (
        .clk(clk), .we(push_ok), .waddr(wptr),
        .wdata({wr_flags, wr_data}), .raddr(rptr), .rdata(head_word)
    );

    assign head_flagged = |head_word[DATA_W +: ERR_W];

    rxef_errcnt #(.DEPTH(DEPTH)) u_errcnt (
        .clk(clk), .rst_n(rst_n),
        .inc(push_ok && (|wr_flags)),
        .dec(pop_ok && head_flagged),
        .cnt(err_cnt), .any(err_any)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            overrun <= 1'b0;
        else if (ovr_pulse && occ == OCC_FULL) overrun <= 1'b1;
        else if (rd_lsr)                       overrun <= 1'b0;
    end

    always_comb begin
        data_ready = (occ != OCC_EMPTY);
        rd_data    = data_ready ? head_word[DATA_W-1:0]      : '0;
        head_err   = data_ready ? head_word[DATA_W +: ERR_W] : '0;
        lsi_req    = err_any | overrun;
    end

    // R6: flagged entries can never outnumber stored entries
    a_r6_err_bound: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= count);
    // R9: a status read with no competing set clears overrun
    a_r9_lsr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && !(ovr_pulse && occ == OCC_FULL)) |=> !overrun);
    // R9: without a status read overrun stays set
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !rd_lsr) |=> overrun);
    // R10: ovr_pulse below full does not raise overrun
    a_r10_ovr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!overrun && ovr_pulse && occ != OCC_FULL) |=> !overrun);
endmodule

// File: tb/test_rx_err_fifo.sv
`timescale 1ns/1ps
module test_rx_err_fifo;
    localparam int DEPTH  = 4;
    localparam int DATA_W = 8;
    localparam real TCLK  = 4.0;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_valid = 0, ovr_pulse = 0, rd_pop = 0, rd_lsr = 0;
    logic [7:0] wr_data = 0;
    logic [2:0] wr_flags = 0;
    logic [7:0] rd_data;
    logic [2:0] head_err;
    logic err_any, overrun, data_ready, lsi_req;

    int checks = 0, errors = 0;
    bit done = 0;
    int mq[DEPTH];
    int mc = 0;
    bit movr = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(TCLK/2) clk = ~clk;

    rx_err_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_rx_err_fifo (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_flags(wr_flags), .ovr_pulse(ovr_pulse), .rd_pop(rd_pop),
        .rd_lsr(rd_lsr), .rd_data(rd_data), .head_err(head_err),
        .err_any(err_any), .overrun(overrun), .data_ready(data_ready),
        .lsi_req(lsi_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int m_flagged();
        int n = 0;
        for (int i = 0; i < mc; i++) if ((mq[i] >> 8) != 0) n++;
        return n;
    endfunction

    task automatic compare();
        int hd = (mc > 0) ? (mq[0] & 8'hFF) : 0;
        int hf = (mc > 0) ? (mq[0] >> 8) : 0;
        int ea = (m_flagged() != 0) ? 1 : 0;
        chk("R2 data_ready", int'(data_ready), (mc != 0) ? 1 : 0);
        chk("R2 rd_data", int'(rd_data), hd);
        chk("R4 head_err", int'(head_err), hf);
        chk("R6 err_any", int'(err_any), ea);
        chk("R9 overrun", int'(overrun), int'(movr));
        chk("R11 lsi_req", int'(lsi_req), (ea != 0 || movr) ? 1 : 0);
    endtask

    // drive one cycle, update model, sample at the following falling edge
    task automatic step(input bit p, input int d, input int f, input bit q,
                        input bit o, input bit l);
        bit full, popok, pushok;
        wr_valid = p; wr_data = d[7:0]; wr_flags = f[2:0];
        rd_pop = q; ovr_pulse = o; rd_lsr = l;
        @(posedge clk);
        full   = (mc == DEPTH);
        popok  = q && (mc > 0);
        pushok = p && !full;
        if (o && full) movr = 1;
        else if (l)    movr = 0;
        if (popok) begin
            for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
            mc--;
        end
        if (pushok) begin
            mq[mc] = (f << 8) | (d & 8'hFF);
            mc++;
        end
        @(negedge clk);
        wr_valid = 0; rd_pop = 0; ovr_pulse = 0; rd_lsr = 0;
        compare();
    endtask

    initial begin
        #(TCLK * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 data_ready", int'(data_ready), 0);
        chk("R1 err_any", int'(err_any), 0);
        chk("R1 overrun", int'(overrun), 0);
        chk("R1 lsi_req", int'(lsi_req), 0);
        chk("R1 head_err", int'(head_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5 R6: every flag combination on a single entry
        for (int f = 0; f < 8; f++) begin
            step(1, 8'h30 + f, f, 0, 0, 0);
            chk("R4 single head_err", int'(head_err), f);
            chk("R6 single err_any", int'(err_any), (f != 0) ? 1 : 0);
            step(0, 0, 0, 1, 0, 0);
            chk("R5 empty head_err", int'(head_err), 0);
            chk("R6 drained err_any", int'(err_any), 0);
        end

        // R12: read on empty ignored
        step(0, 0, 0, 1, 0, 0);
        chk("R12 empty stays", int'(data_ready), 0);

        // R3 R6: fill with one break entry at the tail, extra write discarded
        step(1, 8'h11, 0, 0, 0, 0);
        step(1, 8'h22, 1, 0, 0, 0);
        step(1, 8'h33, 0, 0, 0, 0);
        step(1, 8'h44, 4, 0, 0, 0);
        step(1, 8'h55, 2, 0, 0, 0);
        chk("R3 discard head", int'(rd_data), 8'h11);
        chk("R10 no ovr pulse no overrun", int'(overrun), 0);
        step(1, 8'h66, 0, 1, 0, 0);
        chk("R3 full write with read dropped", int'(data_ready), 1);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        chk("R6 flagged tail keeps err_any", int'(err_any), 1);
        chk("R4 tail head_err break", int'(head_err), 4);
        step(0, 0, 0, 1, 0, 0);
        chk("R6 cleared after last", int'(err_any), 0);

        // R8 R9 R10 R11
        step(0, 0, 0, 0, 1, 0);
        chk("R10 ovr on empty", int'(overrun), 0);
        for (int i = 0; i < DEPTH; i++) step(1, 8'hA0 + i, 0, 0, 0, 0);
        step(1, 8'hEE, 3, 0, 1, 0);
        chk("R8 overrun set", int'(overrun), 1);
        chk("R11 lsi from overrun", int'(lsi_req), 1);
        chk("R8 discarded no error", int'(err_any), 0);
        for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0, 0);
        chk("R9 drain keeps overrun", int'(overrun), 1);
        step(0, 0, 0, 0, 0, 1);
        chk("R9 lsr clears", int'(overrun), 0);
        for (int i = 0; i < DEPTH; i++) step(1, i, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 1);
        chk("R9 set wins over clear", int'(overrun), 1);
        step(0, 0, 0, 0, 0, 1);
        for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0, 0);

        // R7: paired flagged write and read in the partial state
        step(1, 8'h01, 1, 0, 0, 0);
        step(1, 8'h02, 2, 1, 0, 0);
        chk("R7 paired err_any", int'(err_any), 1);
        step(1, 8'h03, 0, 1, 0, 0);
        chk("R7 clean push flagged pop", int'(err_any), 0);
        step(0, 0, 0, 1, 0, 0);

        // R4 sweep: every flag value in every slot of a full store
        for (int f = 0; f < 8; f++) begin
            for (int i = 0; i < DEPTH; i++) step(1, f * 16 + i, (f + i) % 8, 0, 0, 0);
            for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0, 0);
        end

        // pseudo-random mix against model (R2 R3 R6 R7 R8 R9 R11 R12)
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[5], int'(lfsr[15:8]), int'(lfsr[3:1]) & ((lfsr[4]) ? 7 : 0),
                 lfsr[6] & lfsr[7] | lfsr[9], lfsr[11] & lfsr[12], lfsr[13] & lfsr[14] & lfsr[2]);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule